// File: doc/BRIEF.md
# Backplane Bus Priority Arbiter

This block decides which of up to three masters owns an 8-bit backplane bus. Two potential masters ask for the bus on active-low request lines and are answered on matching active-low acknowledge lines. The third master is the board that hosts the arbiter. It has the lowest priority and keeps the bus whenever no request is pending. Ownership is settled again before every transfer, so no master holds the bus across more than one transfer unless it keeps asking for it. Software plays no part in this: a master gains the bus by requesting it, with no register access.

Each request passes through a synchronizer chain. A fixed-priority pick is then made among the synchronized requests. Request 0 beats request 1, and request 1 beats the hosting board. The pick replaces the current owner only while the address strobe is released, that is, between transfers. A mode input switches the arbiter off so that another board can host it. In that mode this board asserts no acknowledge and releases its acknowledge drivers.

Top module: `bus_prio_arbiter`

## Requirements
- R1: While the synchronous active-high reset is applied, and on the first sample after it, `ackN` is 2'b11. With `arbEnable` high, `dfltGrant` is 1.
- R2: When both requests are low (asserted) and the strobe is released, `ackN[0]` goes low and `ackN[1]` stays high, so `ackN` = 2'b10.
- R3: When only request 1 is asserted and the strobe is released, `ackN` = 2'b01.
- R4: When neither request is asserted and the strobe is released, `ackN` = 2'b11 and `dfltGrant` = 1. The bus is parked on the hosting board.
- R5: While `addrStbN` is low, the owner does not change. This holds even when a higher-priority request arrives or the owner withdraws its request. The new choice takes effect at the first rising edge on which `addrStbN` is high.
- R6: At most one bit of `ackN` is low at any time. `dfltGrant` is 0 whenever any bit of `ackN` is low.
- R7: A request change on `reqN` reaches `ackN` on the third rising edge after it is applied (two synchronizer stages plus the owner register), and not before.
- R8: With `arbEnable` low, `ackOe` is 0 and `dfltGrant` is 0 at once. `ackN` is 2'b11 from the next rising edge onward, whatever the requests or the strobe.
- R9: Ownership is re-decided on every idle cycle. If a granted master drops its request while another is pending, the bus moves to the pending master without first parking on the hosting board.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| arbEnable | input | 1 | 1: this board hosts the arbiter; 0: requester or slave mode, arbiter off |
| reqN | input | 2 | Bus requests, active low; bit 0 has the highest priority |
| addrStbN | input | 1 | Address strobe, active low; low means a transfer is in progress |
| ackN | output | 2 | Bus acknowledges, active low; bit n answers reqN[n] |
| ackOe | output | 1 | Output enable for the acknowledge drivers |
| dfltGrant | output | 1 | Internal grant to the hosting board, active high |

## Verification
The bench targets a higher-priority request that arrives in the middle of a transfer. A design that ignores the strobe would move the acknowledge while the owner's strobe is still low, and two masters would then drive the bus. It also counts edges from a request change to the acknowledge: a missing synchronizer stage shows up one cycle early, and an extra stage one cycle late. Handover between the two requesters is checked directly, because a design that parks on the hosting board in between would show a spurious `dfltGrant` cycle. Finally, the bench turns the mode off while a grant is held, to catch an acknowledge that stays low after the arbiter has been disabled.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic park;   // clear the owner: bus goes to the hosting board
    logic load;   // take the new priority winner as owner
  } arbStrobes_t;

endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
(
  input  logic        arbEnable,
  input  logic        addrStbN,
  output arbStrobes_t strobes
);

  // A new owner may only be taken between transfers; a disabled
  // arbiter always parks and never loads.
  always_comb begin
    strobes.park = ~arbEnable;
    strobes.load = arbEnable & addrStbN;
  end

endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int NUM_REQ     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] reqN,
  input  arbStrobes_t        strobes,
  output logic [NUM_REQ-1:0] ackN,
  output logic               ownerIdle
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [NUM_REQ-1:0] syncReg [SYNC_STAGES];
  logic [NUM_REQ-1:0] reqAct;
  logic [NUM_REQ-1:0] winner;
  logic [NUM_REQ:0]   lowerBusy;
  logic [NUM_REQ-1:0] owner;

  // Request synchronizer chain; idle value is all ones (released).
  always_ff @(posedge clk) begin
    if (rst) syncReg[0] <= '1;
    else     syncReg[0] <= reqN;
  end

  generate
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) syncReg[s] <= '1;
        else     syncReg[s] <= syncReg[s-1];
      end
    end
  endgenerate

  assign reqAct = ~syncReg[LAST_STAGE];

  // Fixed priority: the lowest index wins.
  assign lowerBusy[0] = 1'b0;
  generate
    for (genvar i = 0; i < NUM_REQ; i++) begin : g_prio
      assign winner[i]      = reqAct[i] & ~lowerBusy[i];
      assign lowerBusy[i+1] = lowerBusy[i] | reqAct[i];
    end
  endgenerate

  // Owner register, one-hot or zero (zero = hosting board).
  always_ff @(posedge clk) begin
    if (rst || strobes.park) owner <= '0;
    else if (strobes.load)   owner <= winner;
  end

  assign ackN      = ~owner;
  assign ownerIdle = ~|owner;

endmodule

// File: rtl/bus_prio_arbiter.sv
module bus_prio_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_REQ     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               arbEnable,
  input  logic [NUM_REQ-1:0] reqN,
  input  logic               addrStbN,
  output logic [NUM_REQ-1:0] ackN,
  output logic               ackOe,
  output logic               dfltGrant
);

  arbStrobes_t strobes;
  logic        ownerIdle;

  arb_ctrl u_ctrl (
    .arbEnable (arbEnable),
    .addrStbN  (addrStbN),
    .strobes   (strobes)
  );

  arb_datapath #(
    .NUM_REQ     (NUM_REQ),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .reqN      (reqN),
    .strobes   (strobes),
    .ackN      (ackN),
    .ownerIdle (ownerIdle)
  );

  assign ackOe     = arbEnable;
  assign dfltGrant = arbEnable & ownerIdle;

endmodule

// File: rtl/bus_prio_arbiter_checker.sv
module bus_prio_arbiter_checker #(
  parameter int NUM_REQ = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               arbEnable,
  input logic               addrStbN,
  input logic [NUM_REQ-1:0] ackN,
  input logic               dfltGrant
);

  // R1: reset releases every acknowledge
  a_r1_reset_release: assert property (@(posedge clk) rst |=> (&ackN));

  // R5: no handover while a transfer is in progress
  a_r5_hold_in_transfer: assert property (@(posedge clk) disable iff (rst)
    (arbEnable && !addrStbN) |=> $stable(ackN));

  // R6: at most one acknowledge low
  a_r6_one_ack: assert property (@(posedge clk) disable iff (rst)
    $countones(~ackN) <= 1);

  // R6: hosting board loses its grant while any acknowledge is low
  a_r6_dflt_exclusive: assert property (@(posedge clk) disable iff (rst)
    (~&ackN) |-> !dfltGrant);

  // R8: disabled arbiter releases all acknowledges on the next edge
  a_r8_disabled_release: assert property (@(posedge clk) disable iff (rst)
    !arbEnable |=> (&ackN));

endmodule

bind bus_prio_arbiter bus_prio_arbiter_checker #(.NUM_REQ(NUM_REQ)) u_checker (
  .clk       (clk),
  .rst       (rst),
  .arbEnable (arbEnable),
  .addrStbN  (addrStbN),
  .ackN      (ackN),
  .dfltGrant (dfltGrant)
);

// File: tb/bus_prio_arbiter_bench.sv
module bus_prio_arbiter_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic       arbEnable;
  logic [1:0] reqN;
  logic       addrStbN;
  logic [1:0] ackN;
  logic       ackOe;
  logic       dfltGrant;

  int testCount = 0;
  int failCount = 0;

  always #2.5 clk = ~clk;

  bus_prio_arbiter u_bus_prio_arbiter (
    .clk       (clk),
    .rst       (rst),
    .arbEnable (arbEnable),
    .reqN      (reqN),
    .addrStbN  (addrStbN),
    .ackN      (ackN),
    .ackOe     (ackOe),
    .dfltGrant (dfltGrant)
  );

  // Vector: {en, reqN[1:0], stbN, expAckN[1:0], expDflt, expOe}
  localparam int NVEC = 8;
  localparam logic [7:0] VEC [NVEC] = '{
    8'b1_11_1_11_1_1,  // R4 idle park
    8'b1_10_1_10_0_1,  // R2 request 0 alone
    8'b1_00_1_10_0_1,  // R2 both requesting, 0 wins
    8'b1_01_1_01_0_1,  // R9 request 0 withdrawn, 1 takes over
    8'b1_11_1_11_1_1,  // R4 back to park
    8'b1_01_1_01_0_1,  // R3 request 1 alone
    8'b0_00_1_11_0_0,  // R8 disabled with both requesting
    8'b1_11_1_11_1_1   // R4 re-enabled idle
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual {ackN,dflt,oe}=%b expected %b", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    failCount++;
    testCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    rst = 1'b1; arbEnable = 1'b1; reqN = 2'b11; addrStbN = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", {ackN, dfltGrant, ackOe}, 4'b11_1_1);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {ackN, dfltGrant, ackOe}, 4'b11_1_1);

    for (int v = 0; v < NVEC; v++) begin
      arbEnable = VEC[v][7];
      reqN      = VEC[v][6:5];
      addrStbN  = VEC[v][4];
      settle();
      check($sformatf("vector %0d (R2/R3/R4/R8/R9)", v),
            {ackN, dfltGrant, ackOe}, VEC[v][3:0]);
    end

    // R7: latency of exactly three edges
    reqN = 2'b10;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R7 early", {ackN, dfltGrant, ackOe}, 4'b11_1_1);
    @(posedge clk);
    @(negedge clk);
    check("R7 on time", {ackN, dfltGrant, ackOe}, 4'b10_0_1);
    reqN = 2'b11;
    settle();

    // R5: parked, transfer in progress, request 1 must wait
    addrStbN = 1'b0;
    reqN = 2'b01;
    repeat (2) settle();
    check("R5 park held", {ackN, dfltGrant, ackOe}, 4'b11_1_1);
    addrStbN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R5 release to 1", {ackN, dfltGrant, ackOe}, 4'b01_0_1);

    // R5: owner 1 keeps bus while higher request arrives mid-transfer
    addrStbN = 1'b0;
    reqN = 2'b00;
    repeat (2) settle();
    check("R5 owner held", {ackN, dfltGrant, ackOe}, 4'b01_0_1);
    addrStbN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R5 release to 0", {ackN, dfltGrant, ackOe}, 4'b10_0_1);

    // R8: disable while granted
    arbEnable = 1'b0;
    #0.5;
    check("R8 immediate", {ackN, dfltGrant, ackOe}, 4'b10_0_0);
    @(posedge clk);
    @(negedge clk);
    check("R8 next edge", {ackN, dfltGrant, ackOe}, 4'b11_0_0);
    addrStbN = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 strobe ignored", {ackN, dfltGrant, ackOe}, 4'b11_0_0);

    // R1: reset mid-grant
    arbEnable = 1'b1; addrStbN = 1'b1;
    settle();
    check("R2 re-grant", {ackN, dfltGrant, ackOe}, 4'b10_0_1);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 mid-grant reset", {ackN, dfltGrant, ackOe}, 4'b11_1_1);

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule